// File: doc/BRIEF.md
# Sixteen-Lane Byte Table Lookup

This block treats one 16-byte vector as a table of sixteen entries and a second 16-byte vector as sixteen independent byte selectors. Every output lane gets the table entry picked by its own selector, and all lanes look up from the same table in the same cycle. It is the hardware form of the vector byte-permute operation that software uses to keep small lookup tables in registers, so that secret indices never reach a memory address.

Instruction sets disagree on what a selector outside 0..15 should return. A two-bit mode input picks the rule. One mode zeroes a lane only when the selector's top bit is set. One mode zeroes every selector above 15. A relaxed mode zeroes the top-bit range and leaves 0x10..0x7F open. In the relaxed mode the block returns the low-nibble entry for those selectors and raises a per-lane flag saying the lane's result is implementation-defined. The result, the flags and a valid strobe are registered, so the latency is one cycle.

Top module: `byte_swizzle_unit`

## Requirements
- R1: In every mode, a lane whose selector byte is 0x00..0x0F returns table byte number `selector`. Table byte k is `table_in[8k+7:8k]`.
- R2: Mode 2'b00 (top-bit rule): a selector with bit 7 set returns 0x00. Any other selector returns the table entry indexed by its low nibble.
- R3: Mode 2'b01 (strict rule): any selector above 0x0F returns 0x00.
- R4: Mode 2'b10 (relaxed rule): selectors 0x80..0xFF return 0x00. Selectors 0x10..0x7F return the entry indexed by their low nibble.
- R5: `dont_care_out[i]` is 1 exactly when lane i was captured in mode 2'b10 with a selector in 0x10..0x7F. In every other case it is 0.
- R6: Mode 2'b11 gives the same results and flags as mode 2'b01.
- R7: `valid_out` equals `valid_in` of the previous cycle. Results for inputs presented with `valid_in` high appear on the next cycle.
- R8: While `valid_in` is low, `result_out` and `dont_care_out` keep their values.
- R9: While reset (`rst_n` low) is held, `valid_out`, `result_out` and `dont_care_out` are all zero.
- R10: Lane i uses only its own selector byte, `sel_in[8i+7:8i]`, and drives only `result_out[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Inputs are valid this cycle |
| mode_in | input | 2 | Out-of-range rule: 00 top-bit, 01 strict, 10 relaxed, 11 strict |
| table_in | input | 128 | Sixteen table bytes, entry k at bits 8k+7:8k |
| sel_in | input | 128 | Sixteen selector bytes, lane i at bits 8i+7:8i |
| valid_out | output | 1 | Registered valid, one cycle after valid_in |
| result_out | output | 128 | Sixteen looked-up bytes, lane i at bits 8i+7:8i |
| dont_care_out | output | 16 | Per-lane flag for relaxed-mode selectors 0x10..0x7F |

## Verification
The hardest condition to reach from the ports is the same selector value hitting each lane under each of the four mode codes while the table contents vary. A lane that is wired or decoded wrongly for one rare combination would otherwise go unseen. The stimulus sweeps a step counter through all 256 values in every mode and gives lane i the selector counter + 17·i. Every lane therefore meets every byte value, and neighbouring lanes hold different high and low nibbles in the same cycle. The table is recomputed each step so that no entry stays fixed. Idle cycles with changing inputs are placed in the sweep to show that the outputs hold, and a reversed-selector pattern confirms that the lanes are independent.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [1:0] {
        MODE_TOPBIT  = 2'b00,
        MODE_STRICT  = 2'b01,
        MODE_RELAXED = 2'b10,
        MODE_ALIAS   = 2'b11
    } swz_mode_e;

    // Per-mode control: which selector classes force a zero, which raise the flag
    typedef struct packed {
        logic zero_top;   // selector top bit set
        logic zero_mid;   // selector above index range but top bit clear
        logic flag_mid;   // mark mid-range selectors as implementation-defined
    } swz_ctrl_t;

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
    import swz_pkg::*;
(
    input  logic [1:0] mode_i,
    output swz_ctrl_t  ctrl_o
);

    always_comb begin
        ctrl_o = '{zero_top: 1'b1, zero_mid: 1'b1, flag_mid: 1'b0};
        unique case (swz_mode_e'(mode_i))
            MODE_TOPBIT: begin
                ctrl_o.zero_mid = 1'b0;
            end
            MODE_RELAXED: begin
                ctrl_o.zero_mid = 1'b0;
                ctrl_o.flag_mid = 1'b1;
            end
            MODE_STRICT, MODE_ALIAS: begin
                ctrl_o.zero_mid = 1'b1;
            end
            default: begin
                ctrl_o.zero_mid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/swz_lane.sv
module swz_lane
    import swz_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0] table_i,
    input  logic [BYTE_W-1:0]       sel_i,
    input  swz_ctrl_t               ctrl_i,
    output logic [BYTE_W-1:0]       data_o,
    output logic                    dc_o
);

    localparam int IDX_W = $clog2(LANES);
    localparam int UP_W  = BYTE_W - IDX_W;

    logic [BYTE_W-1:0] entry [LANES];

    for (genvar e = 0; e < LANES; e++) begin : g_entry
        assign entry[e] = table_i[e*BYTE_W +: BYTE_W];
    end

    logic [IDX_W-1:0] idx;
    logic [UP_W-1:0]  upper;
    logic             top_set;
    logic             mid_rng;
    logic             kill;

    always_comb begin
        idx     = sel_i[IDX_W-1:0];
        upper   = sel_i[BYTE_W-1:IDX_W];
        top_set = sel_i[BYTE_W-1];
        mid_rng = (upper != '0) && !top_set;
        kill    = (top_set && ctrl_i.zero_top) || (mid_rng && ctrl_i.zero_mid);
        data_o  = kill ? '0 : entry[idx];
        dc_o    = mid_rng && ctrl_i.flag_mid;
    end

endmodule

// File: rtl/byte_swizzle_unit.sv
module byte_swizzle_unit
    import swz_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic [1:0]              mode_in,
    input  logic [LANES*BYTE_W-1:0] table_in,
    input  logic [LANES*BYTE_W-1:0] sel_in,
    output logic                    valid_out,
    output logic [LANES*BYTE_W-1:0] result_out,
    output logic [LANES-1:0]        dont_care_out
);

    localparam int VEC_W = LANES * BYTE_W;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] result;
        logic [LANES-1:0] dc;
    } state_t;

    state_t st_d, st_q;

    swz_ctrl_t        ctrl;
    logic [VEC_W-1:0] lane_data;
    logic [LANES-1:0] lane_dc;

    swz_mode_decode u_dec (
        .mode_i (mode_in),
        .ctrl_o (ctrl)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        swz_lane #(
            .LANES  (LANES),
            .BYTE_W (BYTE_W)
        ) u_lane (
            .table_i (table_in),
            .sel_i   (sel_in[l*BYTE_W +: BYTE_W]),
            .ctrl_i  (ctrl),
            .data_o  (lane_data[l*BYTE_W +: BYTE_W]),
            .dc_o    (lane_dc[l])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            st_d.result = lane_data;
            st_d.dc     = lane_dc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out     = st_q.valid;
    assign result_out    = st_q.result;
    assign dont_care_out = st_q.dc;

endmodule

// File: rtl/swz_chk.sv
module swz_chk #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    valid_in,
    input logic [1:0]              mode_in,
    input logic [LANES*BYTE_W-1:0] table_in,
    input logic [LANES*BYTE_W-1:0] sel_in,
    input logic                    valid_out,
    input logic [LANES*BYTE_W-1:0] result_out,
    input logic [LANES-1:0]        dont_care_out
);

    localparam int IDX_W = $clog2(LANES);

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    function automatic logic [BYTE_W-1:0] entry_at(input logic [LANES*BYTE_W-1:0] t,
                                                   input logic [IDX_W-1:0] n);
        return t[n*BYTE_W +: BYTE_W];
    endfunction

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        valid_out == $past(valid_in));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(valid_in) |-> ($stable(result_out) && $stable(dont_care_out)));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R1
        in_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
            ($past(valid_in) && $past(sel_in[g*BYTE_W+IDX_W +: BYTE_W-IDX_W]) == '0)
            |-> result_out[g*BYTE_W +: BYTE_W] ==
                $past(entry_at(table_in, sel_in[g*BYTE_W +: IDX_W])));

        // R3, R6
        strict_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
            ($past(valid_in) && $past(mode_in[0]) &&
             $past(sel_in[g*BYTE_W+IDX_W +: BYTE_W-IDX_W]) != '0)
            |-> result_out[g*BYTE_W +: BYTE_W] == '0);

        // R2, R4
        top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
            ($past(valid_in) && $past(sel_in[g*BYTE_W+BYTE_W-1]))
            |-> result_out[g*BYTE_W +: BYTE_W] == '0);

        // R5
        flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
            ($past(valid_in) && $past(mode_in) != 2'b10) |-> !dont_care_out[g]);
    end

endmodule

bind byte_swizzle_unit swz_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_byte_swizzle_unit.sv
`timescale 1ns/1ps
module sim_byte_swizzle_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         valid_in;
    logic [1:0]   mode_in;
    logic [127:0] table_in;
    logic [127:0] sel_in;
    logic         valid_out;
    logic [127:0] result_out;
    logic [15:0]  dont_care_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic         exp_valid;
    logic [127:0] exp_res;
    logic [15:0]  exp_dc;

    always #5 clk = ~clk;

    byte_swizzle_unit u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_in      (valid_in),
        .mode_in       (mode_in),
        .table_in      (table_in),
        .sel_in        (sel_in),
        .valid_out     (valid_out),
        .result_out    (result_out),
        .dont_care_out (dont_care_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] ref_byte(input int m, input logic [127:0] t, input int s);
        int ent;
        ent = s % 16;
        if (s < 16) return t[8*s +: 8];
        if (s >= 128) return 8'h00;
        if (m == 1 || m == 3) return 8'h00;
        return t[8*ent +: 8];
    endfunction

    function automatic string lane_tag(input int m, input int s);
        if (s < 16) return "R1";
        if (m == 0) return "R2";
        if (m == 1) return "R3";
        if (m == 2) return "R4";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, wait one edge, compare at the following negedge
    task automatic step(input logic v, input int m, input logic [127:0] t,
                        input logic [127:0] s, input string force_tag);
        string tg;
        valid_in = v;
        mode_in  = m[1:0];
        table_in = t;
        sel_in   = s;
        exp_valid = v;
        if (v) begin
            for (int i = 0; i < 16; i++) begin
                int sv;
                sv = int'(s[8*i +: 8]);
                exp_res[8*i +: 8] = ref_byte(m, t, sv);
                exp_dc[i] = (m == 2) && (sv >= 16) && (sv < 128);
            end
        end
        @(posedge clk);
        @(negedge clk);
        check("R7", {127'd0, valid_out}, {127'd0, exp_valid});
        for (int i = 0; i < 16; i++) begin
            if (force_tag != "") tg = force_tag;
            else if (!v) tg = "R8";
            else tg = lane_tag(m, int'(s[8*i +: 8]));
            check(tg, {120'd0, result_out[8*i +: 8]}, {120'd0, exp_res[8*i +: 8]});
        end
        check(v ? "R5" : "R8", {112'd0, dont_care_out}, {112'd0, exp_dc});
    endtask

    function automatic logic [127:0] make_table(input int m, input int s);
        logic [127:0] t;
        for (int k = 0; k < 16; k++) t[8*k +: 8] = 8'((k*29 + m*61 + s*7 + 1) & 255);
        return t;
    endfunction

    function automatic logic [127:0] make_sel(input int s);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'((s + 17*i) & 255);
        return r;
    endfunction

    initial begin
        rst_n    = 1'b0;
        valid_in = 1'b1;
        mode_in  = 2'b10;
        table_in = {16{8'hA5}};
        sel_in   = {16{8'h23}};
        exp_valid = 1'b0;
        exp_res   = '0;
        exp_dc    = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset holds everything at zero even with valid inputs applied
        check("R9", {127'd0, valid_out}, 128'd0);
        check("R9", result_out, 128'd0);
        check("R9", {112'd0, dont_care_out}, 128'd0);
        rst_n    = 1'b1;
        valid_in = 1'b0;
        @(posedge clk);
        @(negedge clk);

        // R10: each lane picks a distinct entry through its own selector
        begin
            logic [127:0] t, s;
            for (int k = 0; k < 16; k++) begin
                t[8*k +: 8] = 8'(8'h10 + k);
                s[8*k +: 8] = 8'(15 - k);
            end
            for (int m = 0; m < 4; m++) step(1'b1, m, t, s, "R10");
        end

        // full selector sweep in every mode, with idle cycles that must hold
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 256; s++) begin
                step(1'b1, m, make_table(m, s), make_sel(s), "");
                if ((s % 32) == 31)
                    step(1'b0, (m + 2) % 4, make_table(m + 5, s), make_sel(s + 3), "");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule